// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This unit performs one add or subtract per issued operation on two 32-bit source words. It reads each word as two unsigned 16-bit lanes, four unsigned 8-bit lanes, two signed 16-bit lanes, or one signed 32-bit value. Three result policies are supported:

- modular wrap-around;
- unsigned clamping;
- halving, where the full-precision sum or difference is shifted right by one, optionally after adding one to round.

An operation is named by a 6-bit group code and a 5-bit sub-operation code. The unit returns the packed result together with an updated copy of the control word. In that copy, the overflow bit is OR-ed with this operation's saturation event.

Operands are captured in an input register stage. The result is registered one cycle later with a valid strobe, so a result appears two clock edges after issue. A new operation may be issued on every cycle.

Top module: `simd_addsub_unit`

## Requirements
- R1: With group 6'b010000, sub-operation 5'b01000 adds and 5'b01001 subtracts two unsigned 16-bit lanes. Lane 0 is bits 15:0 and lane 1 is bits 31:16. Each lane keeps only the low 16 bits of its own result, and no carry or borrow crosses between lanes.
- R2: With group 6'b010000 and sub-operation 5'b01100, any lane whose unsigned sum exceeds 0xFFFF yields 0xFFFF and sets control bit 20 of the output control word.
- R3: With group 6'b010000 and sub-operation 5'b01101, any lane whose first operand is below its second yields 0x0000 and sets control bit 20.
- R4: With group 6'b011000, sub-operations 5'b00000 (add) and 5'b00001 (subtract) treat the words as four unsigned bytes. Each byte result is bits 8:1 of the 9-bit two's-complement sum or difference.
- R5: In group 6'b011000, sub-operation bit 1 set selects rounding. One is added to the full-precision sum or difference before the right shift. This applies to bytes (00010/00011), signed halves (01010/01011) and words (10010/10011).
- R6: With group 6'b011000, sub-operations 5'b01000 (add) and 5'b01001 (subtract) treat the words as two signed 16-bit lanes. Each lane result is bits 16:1 of the 17-bit signed sum or difference.
- R7: With group 6'b011000, sub-operations 5'b10000 (add) and 5'b10001 (subtract) treat each word as one signed 32-bit value. The result is bits 32:1 of the exact signed sum or difference.
- R8: Every operation other than 01100 and 01101 in group 010000 returns the control word exactly as it was presented.
- R9: A control bit 20 already set on input is still set in the output control word, whatever the operation.
- R10: Any group and sub-operation pair not listed in R1 to R7 returns a zero result and the unchanged control word.
- R11: After reset, the valid strobe, result and control word outputs are zero. The valid strobe rises exactly two clock edges after an issue and lasts one cycle for each issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Issue strobe for the operands on this edge |
| inFunct | input | 6 | Operation group code |
| inSubOp | input | 5 | Sub-operation code within the group |
| inA | input | 32 | First source word |
| inB | input | 32 | Second source word |
| ctrlIn | input | 32 | Current control word |
| outValid | output | 1 | Result strobe, one cycle per issue |
| outResult | output | 32 | Packed result |
| ctrlOut | output | 32 | Control word with bit 20 updated |

## Verification
A lane-boundary or sign-extension fault in the shared lanes corrupts exactly one packed lane of `outResult` in the cycle the strobe rises. Sweeping operands such as 0x7FFF, 0x8000 and 0xFFFF across both halves therefore shows which lane and which format is at fault. A wrong decode of the clamping flags shows either as bit 20 of `ctrlOut` appearing on a modular operation or as a clamped lane without the flag, on the same result cycle. A stuck or misaligned stage register appears as a strobe arriving one cycle early or late, or as results pairing with the wrong operands on back-to-back issues.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

  localparam logic [5:0] GRP_PAIR  = 6'b010000;
  localparam logic [5:0] GRP_HALVE = 6'b011000;

  typedef enum logic [2:0] {
    FMT_NONE,
    FMT_UH,
    FMT_UB,
    FMT_SH,
    FMT_SW
  } fmt_e;

  typedef struct packed {
    fmt_e fmt;
    logic isSub;
    logic sat;
    logic round;
  } strobes_t;

endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         isSub,
  input  logic         isSigned,
  input  logic         addOne,
  output logic [W:0]   full
);
  logic [W:0] extA, extB, raw;

  always_comb begin
    extA = {isSigned & a[W-1], a};
    extB = {isSigned & b[W-1], b};
    raw  = isSub ? (extA - extB) : (extA + extB);
    full = raw + {{W{1'b0}}, addOne};
  end
endmodule

// File: rtl/simd_addsub_ctrl.sv
module simd_addsub_ctrl
  import simd_addsub_pkg::*;
(
  input  logic [5:0] funct,
  input  logic [4:0] subOp,
  output strobes_t   strobes
);
  always_comb begin
    strobes       = '0;
    strobes.fmt   = FMT_NONE;
    if (funct == GRP_PAIR && subOp[4:3] == 2'b01 && subOp[1] == 1'b0) begin
      strobes.fmt   = FMT_UH;
      strobes.isSub = subOp[0];
      strobes.sat   = subOp[2];
    end else if (funct == GRP_HALVE && subOp[2] == 1'b0) begin
      strobes.isSub = subOp[0];
      strobes.round = subOp[1];
      unique case (subOp[4:3])
        2'b00:   strobes.fmt = FMT_UB;
        2'b01:   strobes.fmt = FMT_SH;
        2'b10:   strobes.fmt = FMT_SW;
        default: begin
          strobes.fmt   = FMT_NONE;
          strobes.isSub = 1'b0;
          strobes.round = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/simd_addsub_datapath.sv
module simd_addsub_datapath
  import simd_addsub_pkg::*;
#(
  parameter int WORD = 32
) (
  input  logic [WORD-1:0] opA,
  input  logic [WORD-1:0] opB,
  input  strobes_t        strobes,
  output logic [WORD-1:0] result,
  output logic            overflow
);
  localparam int NHALF = WORD / 16;
  localparam int NBYTE = WORD / 8;

  logic [16:0]   halfFull [NHALF];
  logic [8:0]    byteFull [NBYTE];
  logic [WORD:0] wordFull;
  logic          halfSigned;

  assign halfSigned = (strobes.fmt == FMT_SH);

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    simd_lane #(.W(16)) u_lane (
      .a(opA[16*h +: 16]), .b(opB[16*h +: 16]),
      .isSub(strobes.isSub), .isSigned(halfSigned),
      .addOne(strobes.round), .full(halfFull[h])
    );
  end

  for (genvar q = 0; q < NBYTE; q++) begin : g_byte
    simd_lane #(.W(8)) u_lane (
      .a(opA[8*q +: 8]), .b(opB[8*q +: 8]),
      .isSub(strobes.isSub), .isSigned(1'b0),
      .addOne(strobes.round), .full(byteFull[q])
    );
  end

  simd_lane #(.W(WORD)) u_word (
    .a(opA), .b(opB),
    .isSub(strobes.isSub), .isSigned(1'b1),
    .addOne(strobes.round), .full(wordFull)
  );

  always_comb begin
    result   = '0;
    overflow = 1'b0;
    unique case (strobes.fmt)
      FMT_UH: begin
        for (int h = 0; h < NHALF; h++) begin
          if (strobes.sat && halfFull[h][16]) begin
            result[16*h +: 16] = {16{~strobes.isSub}};
            overflow = 1'b1;
          end else begin
            result[16*h +: 16] = halfFull[h][15:0];
          end
        end
      end
      FMT_SH: begin
        for (int h = 0; h < NHALF; h++) result[16*h +: 16] = 16'(halfFull[h] >> 1);
      end
      FMT_UB: begin
        for (int q = 0; q < NBYTE; q++) result[8*q +: 8] = 8'(byteFull[q] >> 1);
      end
      FMT_SW:  result = WORD'(wordFull >> 1);
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
  import simd_addsub_pkg::*;
#(
  parameter int WORD     = 32,
  parameter int FLAG_BIT = 20
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [5:0]      inFunct,
  input  logic [4:0]      inSubOp,
  input  logic [WORD-1:0] inA,
  input  logic [WORD-1:0] inB,
  input  logic [WORD-1:0] ctrlIn,
  output logic            outValid,
  output logic [WORD-1:0] outResult,
  output logic [WORD-1:0] ctrlOut
);
  logic            stgValid;
  logic [5:0]      stgFunct;
  logic [4:0]      stgSubOp;
  logic [WORD-1:0] stgA, stgB, stgCtrl;
  strobes_t        strobes;
  logic [WORD-1:0] dpResult;
  logic            dpOverflow;

  // input stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgValid <= 1'b0;
      stgFunct <= '0;
      stgSubOp <= '0;
      stgA     <= '0;
      stgB     <= '0;
      stgCtrl  <= '0;
    end else begin
      stgValid <= inValid;
      if (inValid) begin
        stgFunct <= inFunct;
        stgSubOp <= inSubOp;
        stgA     <= inA;
        stgB     <= inB;
        stgCtrl  <= ctrlIn;
      end
    end
  end

  simd_addsub_ctrl u_ctrl (
    .funct(stgFunct), .subOp(stgSubOp), .strobes(strobes)
  );

  simd_addsub_datapath #(.WORD(WORD)) u_dp (
    .opA(stgA), .opB(stgB), .strobes(strobes),
    .result(dpResult), .overflow(dpOverflow)
  );

  // output stage: sticky flag is OR-ed, never cleared (R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outResult <= '0;
      ctrlOut   <= '0;
    end else begin
      outValid <= stgValid;
      if (stgValid) begin
        outResult <= dpResult;
        ctrlOut   <= stgCtrl | (WORD'(dpOverflow) << FLAG_BIT);
      end
    end
  end
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
  parameter int WORD     = 32,
  parameter int FLAG_BIT = 20
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic            stgValid,
  input logic [5:0]      stgFunct,
  input logic [4:0]      stgSubOp,
  input logic [WORD-1:0] stgCtrl,
  input logic            outValid,
  input logic [WORD-1:0] outResult,
  input logic [WORD-1:0] ctrlOut
);
  logic satAdd, satSub, knownOp;

  always_comb begin
    satAdd  = (stgFunct == 6'b010000) && (stgSubOp == 5'b01100);
    satSub  = (stgFunct == 6'b010000) && (stgSubOp == 5'b01101);
    knownOp = ((stgFunct == 6'b010000) && (stgSubOp[4:3] == 2'b01) && !stgSubOp[1]) ||
              ((stgFunct == 6'b011000) && !stgSubOp[2] && (stgSubOp[4:3] != 2'b11));
  end

  a_r11_issue: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> stgValid);
  a_r11_strobe: assert property (@(posedge clk) disable iff (!rstN)
    stgValid |=> outValid);
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !stgValid |=> !outValid);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (stgValid && stgCtrl[FLAG_BIT]) |=> ctrlOut[FLAG_BIT]);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (stgValid && !satAdd && !satSub) |=> (ctrlOut == $past(stgCtrl)));
  a_r2_clamp_high: assert property (@(posedge clk) disable iff (!rstN)
    (stgValid && satAdd && !stgCtrl[FLAG_BIT]) |=>
      (!ctrlOut[FLAG_BIT] || outResult[15:0] == 16'hFFFF || outResult[31:16] == 16'hFFFF));
  a_r3_clamp_low: assert property (@(posedge clk) disable iff (!rstN)
    (stgValid && satSub && !stgCtrl[FLAG_BIT]) |=>
      (!ctrlOut[FLAG_BIT] || outResult[15:0] == 16'h0000 || outResult[31:16] == 16'h0000));
  a_r10_unknown: assert property (@(posedge clk) disable iff (!rstN)
    (stgValid && !knownOp) |=> (outResult == '0));
endmodule

bind simd_addsub_unit simd_addsub_chk #(.WORD(WORD), .FLAG_BIT(FLAG_BIT)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .stgValid(stgValid),
  .stgFunct(stgFunct), .stgSubOp(stgSubOp), .stgCtrl(stgCtrl),
  .outValid(outValid), .outResult(outResult), .ctrlOut(ctrlOut)
);

// File: tb/simd_addsub_unit_tb.sv
`timescale 1ns/1ps
module simd_addsub_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [5:0]  inFunct = '0;
  logic [4:0]  inSubOp = '0;
  logic [31:0] inA = '0, inB = '0, ctrlIn = '0;
  logic        outValid;
  logic [31:0] outResult, ctrlOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  simd_addsub_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFunct(inFunct),
    .inSubOp(inSubOp), .inA(inA), .inB(inB), .ctrlIn(ctrlIn),
    .outValid(outValid), .outResult(outResult), .ctrlOut(ctrlOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [5:0] f, input logic [4:0] s,
                                input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] ci,
                                output logic [31:0] r, output logic [31:0] co);
    bit ovf = 0;
    int rnd = s[1] ? 1 : 0;
    r = '0;
    if (f == 6'h10 && (s == 5'h08 || s == 5'h09 || s == 5'h0C || s == 5'h0D)) begin
      for (int k = 0; k < 2; k++) begin
        int x = int'(a[16*k +: 16]);
        int y = int'(b[16*k +: 16]);
        int d = s[0] ? x - y : x + y;
        if (s[2] && d > 65535) begin r[16*k +: 16] = 16'hFFFF; ovf = 1; end
        else if (s[2] && d < 0) begin r[16*k +: 16] = 16'h0000; ovf = 1; end
        else r[16*k +: 16] = 16'(d);
      end
    end else if (f == 6'h18 && s[2] == 1'b0 && s[4:3] == 2'b00) begin
      for (int k = 0; k < 4; k++) begin
        int x = int'(a[8*k +: 8]);
        int y = int'(b[8*k +: 8]);
        int d = (s[0] ? x - y : x + y) + rnd;
        r[8*k +: 8] = 8'(d >>> 1);
      end
    end else if (f == 6'h18 && s[2] == 1'b0 && s[4:3] == 2'b01) begin
      for (int k = 0; k < 2; k++) begin
        int x = int'($signed(a[16*k +: 16]));
        int y = int'($signed(b[16*k +: 16]));
        int d = (s[0] ? x - y : x + y) + rnd;
        r[16*k +: 16] = 16'(d >>> 1);
      end
    end else if (f == 6'h18 && s[2] == 1'b0 && s[4:3] == 2'b10) begin
      longint x = longint'($signed(a));
      longint y = longint'($signed(b));
      longint d = (s[0] ? x - y : x + y) + longint'(rnd);
      r = 32'(d >>> 1);
    end
    co = ci | (ovf ? 32'h0010_0000 : 32'h0);
  endfunction

  // called at a falling edge; returns at a falling edge
  task automatic run(input logic [5:0] f, input logic [4:0] s, input logic [31:0] a,
                     input logic [31:0] b, input logic [31:0] ci, input string tag,
                     input string ctag);
    logic [31:0] er, ec;
    model(f, s, a, b, ci, er, ec);
    inFunct = f; inSubOp = s; inA = a; inB = b; ctrlIn = ci; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    inA = ~a; inB = ~b; ctrlIn = ~ci;
    @(posedge clk);
    @(negedge clk);
    check({tag, " result"}, outResult, er);
    check({ctag, " ctrl"}, ctrlOut, ec);
  endtask

  logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                            16'hFFFF, 16'h1234, 16'hABCD, 16'h00FF};
  logic [5:0]  opF [16] = '{6'h10, 6'h10, 6'h10, 6'h10, 6'h18, 6'h18, 6'h18, 6'h18,
                            6'h18, 6'h18, 6'h18, 6'h18, 6'h18, 6'h18, 6'h18, 6'h18};
  logic [4:0]  opS [16] = '{5'h08, 5'h09, 5'h0C, 5'h0D, 5'h00, 5'h01, 5'h02, 5'h03,
                            5'h08, 5'h09, 5'h0A, 5'h0B, 5'h10, 5'h11, 5'h12, 5'h13};
  string       opT [16] = '{"R1", "R1", "R2", "R3", "R4", "R4", "R5", "R5",
                            "R6", "R6", "R5", "R5", "R7", "R7", "R5", "R5"};

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset valid", {31'b0, outValid}, 32'h0);
    check("R11 reset result", outResult, 32'h0);
    check("R11 reset ctrl", ctrlOut, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R11 latency: strobe low one edge after issue, high after two, then low
    inFunct = 6'h10; inSubOp = 5'h08; inA = 32'h0001_0002; inB = 32'h0003_0004;
    ctrlIn = 32'h0; inValid = 1'b1;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    check("R11 strobe after one edge", {31'b0, outValid}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R11 strobe after two edges", {31'b0, outValid}, 32'h1);
    check("R11 latency result", outResult, 32'h0004_0006);
    @(posedge clk); @(negedge clk);
    check("R11 strobe single cycle", {31'b0, outValid}, 32'h0);

    // sweep all listed operations over lane corner values
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [31:0] a = {vals[i], vals[(i + 3) % 8]};
          logic [31:0] b = {vals[j], vals[(j + 5) % 8]};
          bit isSat = (opF[op] == 6'h10) && opS[op][2];
          run(opF[op], opS[op], a, b, 32'h5A00_0003, opT[op], isSat ? opT[op] : "R8");
        end
      end
    end

    // R9 sticky flag: already set, no new overflow
    run(6'h10, 5'h0C, 32'h0001_0001, 32'h0001_0001, 32'h0010_0000, "R9", "R9");
    run(6'h18, 5'h10, 32'h0000_0004, 32'h0000_0002, 32'h0010_0040, "R9", "R9");
    run(6'h10, 5'h0D, 32'h0000_0005, 32'h0000_0009, 32'h0010_0000, "R9", "R9");

    // R10 unlisted codes
    run(6'h10, 5'h00, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_1111, "R10", "R10");
    run(6'h18, 5'h18, 32'h1234_5678, 32'h1111_1111, 32'h0000_2222, "R10", "R10");
    run(6'h18, 5'h04, 32'h1234_5678, 32'h1111_1111, 32'h0000_3333, "R10", "R10");
    run(6'h11, 5'h08, 32'h1234_5678, 32'h1111_1111, 32'h0010_0000, "R10", "R10");
    run(6'h10, 5'h0A, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, "R10", "R10");

    // R2 and R3 directed: one lane clamps, other lane exact
    run(6'h10, 5'h0C, 32'hFFF0_0010, 32'h0020_0020, 32'h0, "R2", "R2");
    run(6'h10, 5'h0D, 32'h0010_0005, 32'h0008_0009, 32'h0, "R3", "R3");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule